// File: doc/BRIEF.md
# Impedance Calibration Command Sequencer

This block sits beside the main command scheduler of a DDR3-style memory controller. It decides when each rank gets an impedance-calibration command. A rank gets the long form after power-up and after it leaves self-refresh. It gets the short form at regular intervals, timed by a built-in interval counter. The block issues a command only when the target rank has every bank closed and the precharge time has run out. It then holds the channel for the whole calibration window.

One calibration resistor serves every rank, so only one calibration window is open at any moment. While a window is open, the block asks the main scheduler to stop all other traffic. It also forces ODT off and keeps CKE high. Power-up requests rank above self-refresh-exit requests, which rank above periodic ones. When two ranks are equal, the lower rank index wins. A long request that arrives for a rank absorbs any short request still waiting for that rank. The DLL lock wait does not affect this block.

Top module: `zq_sched`

## Requirements
- R1: While reset is high and in the cycle after it, `zq_go`, `zq_long`, `chan_hold`, `odt_off` and `cke_keep` are all low.
- R2: A pulse on `req_init[r]` leads to one command for rank r with `zq_long` high (address bit A10 high). The window that follows lasts `T_INIT` cycles.
- R3: A pulse on `req_srx[r]` leads to one command for rank r with `zq_long` high. The window that follows lasts `T_OPER` cycles.
- R4: While `per_en` is high, every `PERIOD` cycles the block raises a short request for each rank. Each request leads to a command with `zq_long` low (A10 low) and a window of `T_SHORT` cycles.
- R5: A command to rank r is issued only on a clock edge where `all_pre[r]` is high and `ts_now - stamp_r >= TRP` (modulo 2^TS_W). Here stamp_r is bits [r*TS_W +: TS_W] of `pre_stamp`.
- R6: `zq_go` is high for exactly one cycle per command. In every other cycle it is low, which means NOP.
- R7: `chan_hold`, `odt_off` and `cke_keep` go high in the same cycle as `zq_go` and stay high for the whole window.
- R8: Only one window is open at a time. A command for a second rank waits until the open window has closed.
- R9: Among pending requests on ready ranks, power-up wins over self-refresh exit, which wins over periodic. Between equal kinds, the lower rank wins.
- R10: A long request for a rank replaces a pending short request for that rank, so only the long command is issued.
- R11: A request stays pending while its rank is not ready. It is served as soon as the rank becomes ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_init | input | NR | Power-up calibration request pulse, one bit per rank |
| req_srx | input | NR | Self-refresh-exit calibration request pulse, one bit per rank |
| per_en | input | 1 | Enables the periodic interval counter; low clears it |
| all_pre | input | NR | All banks of the rank are precharged |
| ts_now | input | TS_W | Current controller timestamp |
| pre_stamp | input | NR*TS_W | Timestamp of the last precharge, per rank |
| zq_go | output | 1 | One-cycle calibration command strobe |
| zq_long | output | 1 | Command type: 1 long (A10 high), 0 short |
| zq_rank | output | RW | Target rank of the command |
| chan_hold | output | 1 | Main scheduler must issue no command |
| odt_off | output | 1 | Force ODT off |
| cke_keep | output | 1 | Keep CKE high |

## Verification
The assertions assume that `all_pre` and `pre_stamp` come from a well-behaved main scheduler, and that `ts_now` advances by one every cycle like a real timestamp counter. They also assume that request pulses last one cycle. The stimulus drives `ts_now` from a free-running bench counter. It keeps every precharge stamp at or behind that counter, and it raises each request for exactly one cycle on the falling edge. Readiness and `per_en` change only between scenarios, or at moments chosen to create a pending request.

// File: rtl/zq_sched_pkg.sv
package zq_sched_pkg;
  // Encoded so that a larger value means higher priority
  typedef enum logic [1:0] {
    ZK_NONE  = 2'd0,
    ZK_SHORT = 2'd1,
    ZK_OPER  = 2'd2,
    ZK_INIT  = 2'd3
  } zq_kind_e;
endpackage

// File: rtl/zq_ptimer.sv
module zq_ptimer #(
  parameter int PERIOD = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/zq_pend.sv
module zq_pend
  import zq_sched_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     init_req,
  input  logic     srx_req,
  input  logic     per_tick,
  input  logic     serve,
  output zq_kind_e kind
);
  zq_kind_e incoming;

  always_comb begin
    if (init_req)     incoming = ZK_INIT;
    else if (srx_req) incoming = ZK_OPER;
    else if (per_tick) incoming = ZK_SHORT;
    else              incoming = ZK_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) kind <= ZK_NONE;
    else if (serve) kind <= incoming;
    else if (incoming > kind) kind <= incoming;
  end
endmodule

// File: rtl/zq_arb.sv
module zq_arb
  import zq_sched_pkg::*;
#(
  parameter int NR = 2,
  parameter int RW = 1
) (
  input  logic [2*NR-1:0] kinds,
  input  logic [NR-1:0]   ready,
  output logic            found,
  output logic [RW-1:0]   sel,
  output zq_kind_e        sel_kind
);
  always_comb begin
    sel_kind = ZK_NONE;
    sel      = '0;
    for (int r = 0; r < NR; r++) begin
      if (ready[r] && (zq_kind_e'(kinds[2*r +: 2]) > sel_kind)) begin
        sel_kind = zq_kind_e'(kinds[2*r +: 2]);
        sel      = RW'(r);
      end
    end
    found = (sel_kind != ZK_NONE);
  end
endmodule

// File: rtl/zq_win.sv
module zq_win
  import zq_sched_pkg::*;
#(
  parameter int T_INIT  = 512,
  parameter int T_OPER  = 256,
  parameter int T_SHORT = 64
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  zq_kind_e kind,
  output logic     busy
);
  localparam int CW = $clog2(T_INIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      case (kind)
        ZK_INIT: cnt <= CW'(T_INIT - 1);
        ZK_OPER: cnt <= CW'(T_OPER - 1);
        default: cnt <= CW'(T_SHORT - 1);
      endcase
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/zq_sched.sv
module zq_sched
  import zq_sched_pkg::*;
#(
  parameter int NR      = 2,
  parameter int TS_W    = 16,
  parameter int TRP     = 11,
  parameter int T_INIT  = 512,
  parameter int T_OPER  = 256,
  parameter int T_SHORT = 64,
  parameter int PERIOD  = 4096,
  localparam int RW     = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NR-1:0]     req_init,
  input  logic [NR-1:0]     req_srx,
  input  logic              per_en,
  input  logic [NR-1:0]     all_pre,
  input  logic [TS_W-1:0]   ts_now,
  input  logic [NR*TS_W-1:0] pre_stamp,
  output logic              zq_go,
  output logic              zq_long,
  output logic [RW-1:0]     zq_rank,
  output logic              chan_hold,
  output logic              odt_off,
  output logic              cke_keep
);
  logic            tick;
  logic [2*NR-1:0] kinds;
  logic [NR-1:0]   ready;
  logic [NR-1:0]   serve;
  logic            found;
  logic [RW-1:0]   sel;
  zq_kind_e        sel_kind;
  logic            busy;
  logic            issue;

  zq_ptimer #(.PERIOD(PERIOD)) u_ptimer (
    .clk(clk), .rst(rst), .en(per_en), .tick(tick)
  );

  for (genvar r = 0; r < NR; r++) begin : g_rank
    logic [TS_W-1:0] age;
    zq_kind_e        k;
    assign age      = ts_now - pre_stamp[r*TS_W +: TS_W];
    assign ready[r] = all_pre[r] && (age >= TS_W'(TRP));
    assign serve[r] = issue && (sel == RW'(r));
    zq_pend u_pend (
      .clk(clk), .rst(rst),
      .init_req(req_init[r]), .srx_req(req_srx[r]),
      .per_tick(tick), .serve(serve[r]), .kind(k)
    );
    assign kinds[2*r +: 2] = k;
  end

  zq_arb #(.NR(NR), .RW(RW)) u_arb (
    .kinds(kinds), .ready(ready),
    .found(found), .sel(sel), .sel_kind(sel_kind)
  );

  assign issue = found && !busy;

  zq_win #(.T_INIT(T_INIT), .T_OPER(T_OPER), .T_SHORT(T_SHORT)) u_win (
    .clk(clk), .rst(rst), .start(issue), .kind(sel_kind), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      zq_go   <= 1'b0;
      zq_long <= 1'b0;
      zq_rank <= '0;
    end else begin
      zq_go   <= issue;
      zq_long <= issue && (sel_kind != ZK_SHORT);
      if (issue) zq_rank <= sel;
    end
  end

  assign chan_hold = busy;
  assign odt_off   = busy;
  assign cke_keep  = busy;
endmodule

// File: rtl/zq_sched_chk.sv
module zq_sched_chk #(
  parameter int NR      = 2,
  parameter int RW      = 1,
  parameter int T_SHORT = 64
) (
  input logic          clk,
  input logic          rst,
  input logic [NR-1:0] all_pre,
  input logic          zq_go,
  input logic [RW-1:0] zq_rank,
  input logic          chan_hold,
  input logic          odt_off,
  input logic          cke_keep
);
  logic [31:0] wlen;

  always_ff @(posedge clk) begin
    if (rst || !chan_hold) wlen <= '0;
    else wlen <= wlen + 1;
  end

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    zq_go |=> !zq_go);

  p_window_open_r7: assert property (@(posedge clk) disable iff (rst)
    zq_go |-> (chan_hold && odt_off && cke_keep));

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(zq_go) |-> !$past(chan_hold));

  p_ready_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(zq_go) |-> ((($past(all_pre) >> zq_rank) & NR'(1)) != '0));

  p_min_window_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(chan_hold) |-> (wlen >= 32'(T_SHORT)));
endmodule

bind zq_sched zq_sched_chk #(.NR(NR), .RW(RW), .T_SHORT(T_SHORT)) u_chk (
  .clk(clk), .rst(rst), .all_pre(all_pre), .zq_go(zq_go), .zq_rank(zq_rank),
  .chan_hold(chan_hold), .odt_off(odt_off), .cke_keep(cke_keep)
);

// File: tb/test_zq_sched.sv
module test_zq_sched;
  localparam int NR = 2, TS_W = 16, TRP = 4;
  localparam int T_INIT = 16, T_OPER = 12, T_SHORT = 6, PERIOD = 200;

  logic clk = 0, rst = 1;
  logic [NR-1:0] req_init = '0, req_srx = '0, all_pre = '0;
  logic per_en = 0;
  logic [TS_W-1:0] ts_now = 16'd1000;
  logic [NR*TS_W-1:0] pre_stamp = '0;
  logic zq_go, zq_long, chan_hold, odt_off, cke_keep;
  logic [0:0] zq_rank;
  int checks = 0, errors = 0;
  bit done = 0;

  zq_sched #(.NR(NR), .TS_W(TS_W), .TRP(TRP), .T_INIT(T_INIT), .T_OPER(T_OPER),
             .T_SHORT(T_SHORT), .PERIOD(PERIOD)) i_zq_sched (
    .clk(clk), .rst(rst), .req_init(req_init), .req_srx(req_srx), .per_en(per_en),
    .all_pre(all_pre), .ts_now(ts_now), .pre_stamp(pre_stamp), .zq_go(zq_go),
    .zq_long(zq_long), .zq_rank(zq_rank), .chan_hold(chan_hold),
    .odt_off(odt_off), .cke_keep(cke_keep));

  always #10 clk = ~clk;
  always @(posedge clk) ts_now <= ts_now + 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_go(input int limit, output bit seen);
    seen = 0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk);
      if (zq_go) seen = 1;
    end
  endtask

  // Called at the negedge where zq_go was seen; returns cycles with hold high
  task automatic hold_len(output int n, output bit sides_ok);
    n = 0; sides_ok = 1;
    while (chan_hold) begin
      if (!(odt_off && cke_keep)) sides_ok = 0;
      n++;
      @(negedge clk);
    end
  endtask

  // Expect one command: rank, long flag, window length
  task automatic expect_cmd(input string req, input int rank, input bit lng,
                            input int win, input int limit);
    bit seen, sides; int n;
    wait_go(limit, seen);
    check(seen, req, seen, 1);
    if (!seen) return;
    check(zq_rank == rank, req, zq_rank, rank);
    check(zq_long == lng, req, zq_long, lng);
    hold_len(n, sides);
    check(n == win, req, n, win);
    check(sides, "R7", sides, 1);
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    bit seen;
    wait_go(cycles, seen);
    check(!seen, req, seen, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!zq_go && !zq_long && !chan_hold && !odt_off && !cke_keep, "R1",
          {zq_go, zq_long, chan_hold, odt_off, cke_keep}, 0);
    rst = 0;
    @(negedge clk);
    check(!zq_go && !chan_hold && !odt_off && !cke_keep, "R1",
          {zq_go, chan_hold, odt_off, cke_keep}, 0);
  endtask

  task automatic t_powerup;  // R2
    all_pre = 2'b11;
    req_init = 2'b01; @(negedge clk); req_init = '0;
    expect_cmd("R2", 0, 1, T_INIT, 10);
  endtask

  task automatic t_trp;  // R5: stamp at current time, issue waits for TRP
    bit seen;
    pre_stamp[0 +: TS_W] = ts_now;
    req_srx = 2'b01; @(negedge clk); req_srx = '0;
    wait_go(20, seen);
    check(seen, "R5", seen, 1);
    check(16'(ts_now - pre_stamp[0 +: TS_W]) == TRP + 1, "R5",
          16'(ts_now - pre_stamp[0 +: TS_W]), TRP + 1);
    check(zq_long && zq_rank == 0, "R3", {zq_long, zq_rank}, 2);
    while (chan_hold) @(negedge clk);
    pre_stamp = '0;
  endtask

  task automatic t_two_srx;  // R3, R8
    req_srx = 2'b11; @(negedge clk); req_srx = '0;
    expect_cmd("R3", 0, 1, T_OPER, 10);
    expect_cmd("R8", 1, 1, T_OPER, 3);
  endtask

  task automatic t_priority;  // R9
    req_init = 2'b10; req_srx = 2'b01; @(negedge clk);
    req_init = '0; req_srx = '0;
    expect_cmd("R9", 1, 1, T_INIT, 10);
    expect_cmd("R9", 0, 1, T_OPER, 3);
  endtask

  task automatic t_wait_ready;  // R11
    all_pre = 2'b00;
    req_srx = 2'b10; @(negedge clk); req_srx = '0;
    expect_quiet("R11", 40);
    all_pre = 2'b10;
    expect_cmd("R11", 1, 1, T_OPER, 5);
    all_pre = 2'b11;
  endtask

  task automatic t_periodic;  // R4, R6
    bit seen;
    per_en = 1;
    expect_cmd("R4", 0, 0, T_SHORT, PERIOD + 10);
    expect_cmd("R4", 1, 0, T_SHORT, 3);
    per_en = 0;
    expect_quiet("R6", 30);
  endtask

  task automatic t_upgrade;  // R10
    all_pre = 2'b00; per_en = 1;
    repeat (PERIOD + 3) @(negedge clk);
    per_en = 0;
    req_srx = 2'b01; @(negedge clk); req_srx = '0;
    all_pre = 2'b11;
    expect_cmd("R10", 0, 1, T_OPER, 5);
    expect_cmd("R10", 1, 0, T_SHORT, 3);
    expect_quiet("R10", 50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    repeat (3) @(negedge clk);
    t_powerup();
    t_trp();
    t_two_srx();
    t_priority();
    t_wait_ready();
    t_periodic();
    t_upgrade();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule